// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Target

This block is the target end of a two-wire serial memory that answers read traffic only. Both bus lines are sampled on the system clock through two-flop synchronizers. SDA is driven open-drain through a single `sdaOe` pull-low enable, and SCL is only observed. The block holds a byte array of `2**ADDR_W` entries and a separate 128-byte identification page, both in registers. A sideband load port fills both stores. A lock input forces the identification page to read as all ones.

A host selects the block with a select byte. The top nibble of that byte is the device type: 1010b addresses the array and 1011b addresses the identification page. The next three bits must equal the `ceStrap` pins, and the lowest bit is the read/write flag. To set a position, the host sends a write-mode select and two address bytes, then issues a repeated Start and a read-mode select. A read-mode select on its own continues from the stored pointer. The array pointer lives on between transactions and wraps over the whole array. Identification-page accesses use their own 7-bit pointer, so they leave the array pointer alone.

`ADDR_W` may range from 9 to 16. The address phase always carries 16 bits, and any bits above `ADDR_W` are discarded.

Top module: `i2c_rd_eeprom`

## Requirements
- R1: Following reset, `sdaOe` is 0 and the block waits for a Start condition.
- R2: A select byte is acknowledged (SDA pulled low during the ninth clock) only when its top nibble is 1010b or 1011b and bits 3:1 equal `ceStrap`. Any other select byte gets no acknowledge, and the block ignores the bus until the next Start, with its pointers unchanged.
- R3: A random read works as follows: a write-mode select, a high address byte and a low address byte, each acknowledged, then a repeated Start and a read-mode select. It returns the array byte at the low `ADDR_W` bits of the 16-bit address, and address bits above `ADDR_W` are ignored.
- R4: A read-mode select without an address phase returns the byte at the array pointer and then increments the pointer. The pointer keeps its value across transactions.
- R5: Each data byte the host acknowledges is followed by the next consecutive byte.
- R6: Reading past the highest array address continues from address 0.
- R7: After the host does not acknowledge a data byte, the block releases SDA and drives nothing more until the next Start.
- R8: Data leaves the block most significant bit first. `sdaOe` changes only while SCL is low.
- R9: With type 1011b, only the low 7 address bits select the identification byte. The identification pointer advances and wraps within its 128 bytes, and the array pointer is not disturbed.
- R10: While `idLock` is 1, every identification-page byte reads as FFh.
- R11: A Stop or a Start in the middle of a byte abandons the transfer. The block goes back to waiting for a select byte, and the array pointer keeps its last value.
- R12: When `ldEn` is 1 at a clock edge, `ldData` is written into the identification page (`ldId`=1, index `ldAddr[6:0]`) or into the array (`ldId`=0, index `ldAddr`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaOe | output | 1 | 1 pulls the data line low |
| ceStrap | input | 3 | Chip-enable strap value matched against select bits 3:1 |
| idLock | input | 1 | 1 makes identification-page reads return FFh |
| ldEn | input | 1 | Sideband load strobe |
| ldId | input | 1 | Sideband target: 1 identification page, 0 array |
| ldAddr | input | ADDR_W | Sideband load index |
| ldData | input | 8 | Sideband load byte |

## Verification
The bench goes after the array wrap from the top address to 0. A design that saturated there, or that stepped into the identification page, would return the wrong third byte. It also reads the identification page across index 7Fh to 00h and then does a current-address array read. A shared or mis-wrapped pointer would show up as a wrong byte in one of those two reads. Strap mismatches, an unknown type code, and Stops or Starts cut into the middle of a byte are each followed by a current-address read. A design that acknowledged stray bytes or loaded a half-received address would return a byte from the wrong position. A monitor watches for any change of `sdaOe` while SCL is high, which is how a release after NACK timed on the wrong edge would appear.

// File: rtl/i2c_rd_pkg.sv
`timescale 1ns/1ps
package i2c_rd_pkg;
  localparam logic [3:0] MEM_TYPE = 4'b1010;
  localparam logic [3:0] ID_TYPE  = 4'b1011;
  localparam int ID_W = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_AH, ST_AH_ACK,
    ST_AL, ST_AL_ACK, ST_WAIT_RS, ST_RD, ST_RD_ACK
  } rdState_t;

  typedef struct packed {
    logic shiftIn;
    logic latchHi;
    logic latchAddr;
    logic loadTx;
    logic shiftTx;
    logic idSel;
  } dpStrobe_t;
endpackage

// File: rtl/i2c_rd_ctrl.sv
`timescale 1ns/1ps
module i2c_rd_ctrl
  import i2c_rd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] ceStrap,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpStrobe_t  strobe,
  output logic       sdaBit,
  output logic       sdaOe
);
  logic [1:0] sclSync, sdaSync;
  logic       sclP, sdaP;
  logic       sclS, sdaS;
  logic       sclRise, sclFall, startEv, stopEv;
  rdState_t   state;
  logic [2:0] bitCnt;
  logic       rxDone, idSelR, rwR, mAck;
  logic       devMatch, rxState, ackState;

  assign sclS    = sclSync[1];
  assign sdaS    = sdaSync[1];
  assign sdaBit  = sdaS;
  assign sclRise = sclS & ~sclP;
  assign sclFall = ~sclS & sclP;
  assign startEv = sclS & sclP & sdaP & ~sdaS;
  assign stopEv  = sclS & sclP & ~sdaP & sdaS;

  assign devMatch = ((rxByte[7:4] == MEM_TYPE) || (rxByte[7:4] == ID_TYPE))
                    && (rxByte[3:1] == ceStrap);
  assign rxState  = (state == ST_DEV) || (state == ST_AH) || (state == ST_AL);
  assign ackState = (state == ST_DEV_ACK) || (state == ST_AH_ACK) || (state == ST_AL_ACK);
  assign sdaOe    = ackState || ((state == ST_RD) && !txBit);

  always_comb begin
    strobe       = '0;
    strobe.idSel = idSelR;
    if (!startEv && !stopEv) begin
      strobe.shiftIn   = rxState && sclRise && !rxDone;
      strobe.latchHi   = (state == ST_AH) && sclFall && rxDone;
      strobe.latchAddr = (state == ST_AL) && sclFall && rxDone;
      strobe.loadTx    = sclFall && (((state == ST_DEV_ACK) && rwR) ||
                                     ((state == ST_RD_ACK) && mAck));
      strobe.shiftTx   = (state == ST_RD) && sclFall && (bitCnt != 3'd7);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
      state   <= ST_IDLE;
      bitCnt  <= '0;
      rxDone  <= 1'b0;
      idSelR  <= 1'b0;
      rwR     <= 1'b0;
      mAck    <= 1'b0;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclP    <= sclS;
      sdaP    <= sdaS;
      if (startEv) begin
        state  <= ST_DEV;
        bitCnt <= '0;
        rxDone <= 1'b0;
      end else if (stopEv) begin
        state  <= ST_IDLE;
        rxDone <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_AH, ST_AL: begin
            if (sclRise && !rxDone) begin
              bitCnt <= bitCnt + 3'd1;
              if (bitCnt == 3'd7) rxDone <= 1'b1;
            end else if (sclFall && rxDone) begin
              rxDone <= 1'b0;
              bitCnt <= '0;
              if (state == ST_DEV) begin
                if (devMatch) begin
                  state  <= ST_DEV_ACK;
                  idSelR <= (rxByte[7:4] == ID_TYPE);
                  rwR    <= rxByte[0];
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_AH) begin
                state <= ST_AH_ACK;
              end else begin
                state <= ST_AL_ACK;
              end
            end
          end
          ST_DEV_ACK: if (sclFall) state <= rwR ? ST_RD : ST_AH;
          ST_AH_ACK:  if (sclFall) state <= ST_AL;
          ST_AL_ACK:  if (sclFall) state <= ST_WAIT_RS;
          ST_RD: begin
            if (sclFall) begin
              if (bitCnt == 3'd7) begin
                state  <= ST_RD_ACK;
                bitCnt <= '0;
                mAck   <= 1'b0;
              end else begin
                bitCnt <= bitCnt + 3'd1;
              end
            end
          end
          ST_RD_ACK: begin
            if (sclRise) mAck <= ~sdaS;
            else if (sclFall) state <= mAck ? ST_RD : ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  // R8
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !sclS);
  // R11
  stop_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> (state == ST_IDLE) && !sdaOe);
  // R11
  start_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> (state == ST_DEV) && (bitCnt == 3'd0));
  // R7
  nack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_RD_ACK) && sclFall && !mAck && !startEv && !stopEv) |=> !sdaOe);
endmodule

// File: rtl/i2c_rd_dpath.sv
`timescale 1ns/1ps
module i2c_rd_dpath
  import i2c_rd_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              sdaBit,
  input  logic              idLock,
  input  logic              ldEn,
  input  logic              ldId,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [7:0]        ldData,
  output logic [7:0]        rxByte,
  output logic              txBit
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int ID_DEPTH = 1 << ID_W;
  localparam int HI_W     = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] CNT_MAX = '1;

  logic [7:0]        mem   [DEPTH];
  logic [7:0]        idMem [ID_DEPTH];
  logic [ADDR_W-1:0] cnt;
  logic [ID_W-1:0]   idPtr;
  logic [HI_W-1:0]   addrHi;
  logic [7:0]        rxSh, txSh, readByte;

  assign rxByte   = rxSh;
  assign txBit    = txSh[7];
  assign readByte = strobe.idSel ? (idLock ? 8'hFF : idMem[idPtr]) : mem[cnt];

  always_ff @(posedge clk) begin
    if (ldEn && !ldId) mem[ldAddr] <= ldData;
    if (ldEn && ldId)  idMem[ldAddr[ID_W-1:0]] <= ldData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      idPtr  <= '0;
      addrHi <= '0;
      rxSh   <= '0;
      txSh   <= 8'hFF;
    end else begin
      if (strobe.shiftIn) rxSh <= {rxSh[6:0], sdaBit};
      if (strobe.latchHi) addrHi <= rxSh[HI_W-1:0];
      if (strobe.latchAddr) begin
        if (strobe.idSel) idPtr <= rxSh[ID_W-1:0];
        else              cnt   <= {addrHi, rxSh};
      end
      if (strobe.loadTx) begin
        txSh <= readByte;
        if (strobe.idSel) idPtr <= idPtr + 1'b1;
        else              cnt   <= cnt + 1'b1;
      end else if (strobe.shiftTx) begin
        txSh <= {txSh[6:0], 1'b1};
      end
    end
  end

  // R6
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadTx && !strobe.idSel && (cnt == CNT_MAX)) |=> (cnt == '0));
  // R9
  id_keeps_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadTx && strobe.idSel) |=> $stable(cnt));
  // R10
  id_locked_ff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadTx && strobe.idSel && idLock) |=> (txSh == 8'hFF));
endmodule

// File: rtl/i2c_rd_eeprom.sv
`timescale 1ns/1ps
module i2c_rd_eeprom
  import i2c_rd_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [2:0]        ceStrap,
  input  logic              idLock,
  input  logic              ldEn,
  input  logic              ldId,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [7:0]        ldData
);
  dpStrobe_t  strobe;
  logic       sdaBit, txBit;
  logic [7:0] rxByte;

  i2c_rd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ceStrap(ceStrap),
    .rxByte(rxByte), .txBit(txBit), .strobe(strobe), .sdaBit(sdaBit), .sdaOe(sdaOe)
  );

  i2c_rd_dpath #(.ADDR_W(ADDR_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaBit(sdaBit), .idLock(idLock),
    .ldEn(ldEn), .ldId(ldId), .ldAddr(ldAddr), .ldData(ldData),
    .rxByte(rxByte), .txBit(txBit)
  );
endmodule

// File: tb/i2c_rd_eeprom_tb.sv
`timescale 1ns/1ps
module i2c_rd_eeprom_tb_top;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;
  localparam int Q = 8;
  localparam logic [3:0] T_MEM = 4'b1010;
  localparam logic [3:0] T_ID  = 4'b1011;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sdaOe, sdaLine;
  logic [2:0] ceStrap = 3'b101;
  logic idLock = 1'b0;
  logic ldEn = 1'b0, ldId = 1'b0;
  logic [AW-1:0] ldAddr = '0;
  logic [7:0] ldData = '0;

  assign sdaLine = mSda & ~sdaOe;

  i2c_rd_eeprom #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .ceStrap(ceStrap), .idLock(idLock), .ldEn(ldEn), .ldId(ldId),
    .ldAddr(ldAddr), .ldData(ldData)
  );

  int checks = 0, failures = 0, highChanges = 0;
  bit done = 1'b0;
  logic [7:0] memModel [DEPTH];
  logic [7:0] idModel [128];
  logic [7:0] rdBuf [8];
  int expCnt = 0;
  logic prevOe = 1'b0;

  // R8 monitor: pull-low enable must not move while SCL is high
  always @(posedge clk) begin
    if (rstN && mScl && (sdaOe != prevOe)) highChanges++;
    prevOe <= sdaOe;
  end

  function automatic logic [7:0] memVal(int a);
    return 8'((a * 37 + (a >> 3)) ^ 8'h5A);
  endfunction
  function automatic logic [7:0] idVal(int a);
    return 8'(8'hC3 ^ (a * 5));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask
  task automatic startCond();
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b0; waitQ();
    mScl = 1'b0; waitQ();
  endtask
  task automatic stopCond();
    mSda = 1'b0; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b1; waitQ();
  endtask
  task automatic writeBit(logic b);
    mSda = b; waitQ();
    mScl = 1'b1; waitQ(); waitQ();
    mScl = 1'b0; waitQ();
  endtask
  task automatic readBit(output logic b);
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    b = sdaLine; waitQ();
    mScl = 1'b0; waitQ();
  endtask
  task automatic sendByte(logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(b);
    acked = ~b;
  endtask
  task automatic recvByte(output logic [7:0] v, input logic hostAck);
    logic b;
    for (int i = 7; i >= 0; i--) begin readBit(b); v[i] = b; end
    writeBit(~hostAck);
  endtask

  // address phase: write-mode select plus two address bytes (R3)
  task automatic setAddr(logic [3:0] typ, logic [15:0] a);
    logic ak;
    startCond();
    sendByte({typ, ceStrap, 1'b0}, ak); check(ak, "R2 select ack", ak, 1);
    sendByte(a[15:8], ak); check(ak, "R3 high addr ack", ak, 1);
    sendByte(a[7:0], ak);  check(ak, "R3 low addr ack", ak, 1);
  endtask
  // read-mode select then n bytes, NACK on the last one, then Stop (R7)
  task automatic readSeq(logic [3:0] typ, int n);
    logic ak;
    startCond();
    sendByte({typ, ceStrap, 1'b1}, ak); check(ak, "R2 read select ack", ak, 1);
    for (int i = 0; i < n; i++) recvByte(rdBuf[i], i < n - 1);
    check(sdaOe == 1'b0, "R7 released after NACK", sdaOe, 0);
    stopCond();
    check(sdaOe == 1'b0, "R7 released after Stop", sdaOe, 0);
  endtask

  task automatic t_reset();
    check(sdaOe == 1'b0, "R1 reset sdaOe", sdaOe, 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++) begin
      memModel[i] = memVal(i);
      ldEn = 1'b1; ldId = 1'b0; ldAddr = AW'(i); ldData = memModel[i];
      @(negedge clk);
    end
    for (int i = 0; i < 128; i++) begin
      idModel[i] = idVal(i);
      ldEn = 1'b1; ldId = 1'b1; ldAddr = AW'(i); ldData = idModel[i];
      @(negedge clk);
    end
    ldEn = 1'b0;
  endtask

  task automatic t_mismatch();
    logic ak;
    startCond();
    sendByte({T_MEM, 3'b010, 1'b0}, ak); check(!ak, "R2 strap mismatch no ack", ak, 0);
    sendByte(8'h12, ak); check(!ak, "R2 ignored after mismatch", ak, 0);
    stopCond();
    startCond();
    sendByte({4'b1100, ceStrap, 1'b1}, ak); check(!ak, "R2 unknown type no ack", ak, 0);
    stopCond();
    readSeq(T_MEM, 1);
    check(rdBuf[0] == memModel[expCnt], "R2 pointer untouched", rdBuf[0], memModel[expCnt]);
    expCnt = (expCnt + 1) % DEPTH;
  endtask

  task automatic t_random();
    setAddr(T_MEM, 16'h0123);
    readSeq(T_MEM, 1);
    check(rdBuf[0] == memModel['h123], "R3 random read R8 msb first", rdBuf[0], memModel['h123]);
    expCnt = 'h124;
  endtask

  task automatic t_current();
    readSeq(T_MEM, 1);
    check(rdBuf[0] == memModel[expCnt], "R4 current read", rdBuf[0], memModel[expCnt]);
    expCnt = (expCnt + 1) % DEPTH;
    readSeq(T_MEM, 1);
    check(rdBuf[0] == memModel[expCnt], "R4 pointer persists", rdBuf[0], memModel[expCnt]);
    expCnt = (expCnt + 1) % DEPTH;
  endtask

  task automatic t_sequential();
    setAddr(T_MEM, 16'h0200);
    readSeq(T_MEM, 4);
    for (int i = 0; i < 4; i++)
      check(rdBuf[i] == memModel['h200 + i], "R5 sequential byte", rdBuf[i], memModel['h200 + i]);
    expCnt = 'h204;
  endtask

  task automatic t_wrap();
    setAddr(T_MEM, 16'(DEPTH - 2));
    readSeq(T_MEM, 3);
    check(rdBuf[0] == memModel[DEPTH - 2], "R6 byte before top", rdBuf[0], memModel[DEPTH - 2]);
    check(rdBuf[1] == memModel[DEPTH - 1], "R6 top byte", rdBuf[1], memModel[DEPTH - 1]);
    check(rdBuf[2] == memModel[0], "R6 wrapped to zero", rdBuf[2], memModel[0]);
    expCnt = 1;
  endtask

  task automatic t_highBits();
    setAddr(T_MEM, 16'hFC10);
    readSeq(T_MEM, 1);
    check(rdBuf[0] == memModel['h010], "R3 high bits ignored", rdBuf[0], memModel['h010]);
    expCnt = 'h011;
  endtask

  task automatic t_id();
    idLock = 1'b0;
    setAddr(T_ID, 16'h1F05);
    readSeq(T_ID, 2);
    check(rdBuf[0] == idModel[5], "R9 id byte low bits", rdBuf[0], idModel[5]);
    check(rdBuf[1] == idModel[6], "R9 id next byte", rdBuf[1], idModel[6]);
    setAddr(T_ID, 16'h007F);
    readSeq(T_ID, 2);
    check(rdBuf[0] == idModel[127], "R9 id last byte", rdBuf[0], idModel[127]);
    check(rdBuf[1] == idModel[0], "R9 id wraps in page", rdBuf[1], idModel[0]);
    readSeq(T_MEM, 1);
    check(rdBuf[0] == memModel[expCnt], "R9 array pointer kept", rdBuf[0], memModel[expCnt]);
    expCnt = (expCnt + 1) % DEPTH;
  endtask

  task automatic t_lock();
    idLock = 1'b1;
    setAddr(T_ID, 16'h0005);
    readSeq(T_ID, 2);
    check(rdBuf[0] == 8'hFF, "R10 locked byte", rdBuf[0], 8'hFF);
    check(rdBuf[1] == 8'hFF, "R10 locked next byte", rdBuf[1], 8'hFF);
    idLock = 1'b0;
  endtask

  task automatic t_abort();
    logic ak;
    startCond();
    sendByte({T_MEM, ceStrap, 1'b0}, ak); check(ak, "R11 select ack", ak, 1);
    sendByte(8'h02, ak); check(ak, "R11 high addr ack", ak, 1);
    writeBit(1'b0); writeBit(1'b1); writeBit(1'b1);
    stopCond();
    readSeq(T_MEM, 1);
    check(rdBuf[0] == memModel[expCnt], "R11 Stop mid-byte", rdBuf[0], memModel[expCnt]);
    expCnt = (expCnt + 1) % DEPTH;
    startCond();
    writeBit(1'b1); writeBit(1'b0); writeBit(1'b1); writeBit(1'b0);
    readSeq(T_MEM, 1);
    check(rdBuf[0] == memModel[expCnt], "R11 Start mid-byte", rdBuf[0], memModel[expCnt]);
    expCnt = (expCnt + 1) % DEPTH;
  endtask

  task automatic t_loadPort();
    ldEn = 1'b1; ldId = 1'b0; ldAddr = AW'('h050); ldData = 8'hE7;
    @(negedge clk);
    ldEn = 1'b0;
    memModel['h050] = 8'hE7;
    setAddr(T_MEM, 16'h0050);
    readSeq(T_MEM, 1);
    check(rdBuf[0] == 8'hE7, "R12 load port write", rdBuf[0], 8'hE7);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_fill();
    t_mismatch();
    t_random();
    t_current();
    t_sequential();
    t_wrap();
    t_highBits();
    t_id();
    t_lock();
    t_abort();
    t_loadPort();
    check(highChanges == 0, "R8 sdaOe steady while SCL high", highChanges, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule